// File: doc/BRIEF.md
# Credit-Aged Variable-Size Replacement Manager

This block keeps track of which configurations of differing sizes currently sit in a reconfigurable array of fixed capacity, and chooses which ones to throw out when a new one must be brought in. Each resident entry remembers its identifier, its size and a credit. A request names a configuration and its size. If the configuration is already resident, its credit is topped back up to its size. If it is not resident, the block throws out entries one at a time until the new one fits and a table slot is free. Each time, it removes the entry whose credit is lowest, and then lowers every surviving credit by the credit of the removed entry. It then issues a load command and adds the load cost to a running latency total.

A large configuration starts with a large credit, so it outlives several small ones. Its protection grows in line with what a reload of it would cost. Each eviction and each load appears as a one-cycle pulse that carries the identifier and size. An outside loader acts on these pulses. Placement inside the array is not the concern of this block, and free space is treated as one pool.

A ready/valid pair accepts one request at a time. A one-cycle response pulse reports a hit, a miss or a rejection.

Top module: `cbr_repl_mgr`

## Requirements
- R1: After reset, req_ready is 1, all four statistics outputs are 0 and no entry is resident, so the first request for any identifier is a miss.
- R2: A request whose identifier is resident responds with resp_hit=1 and resp_err=0. It causes no eviction and no load, adds 1 to hit_cnt, and sets that entry's credit to its stored size.
- R3: A request that misses and finds both enough free capacity and a free slot loads at once, with no eviction. load_valid pulses with load_id and load_size equal to the request, the entry goes into the lowest-numbered free slot, miss_cnt increments, and the response has resp_hit=0 and resp_err=0.
- R4: On a miss, evictions repeat for as long as the free capacity (CAPACITY minus the sum of resident sizes) is below the requested size, or no slot is free. Each eviction pulses evict_valid with the victim's identifier and size and increments evict_cnt.
- R5: Each eviction removes the resident entry with the smallest credit. On equal credits, the entry in the lowest-numbered slot is removed.
- R6: After each eviction, the victim's credit is subtracted from the credit of every remaining resident entry.
- R7: A newly loaded entry starts with a credit equal to its size.
- R8: Every load adds size × LAT_PER_UNIT to lat_total. Hits, misses and evictions each increment their own counter.
- R9: A request with size greater than CAPACITY responds with resp_err=1. It causes no eviction and no load, leaves every counter and the resident set unchanged, and does not count as a miss.
- R10: req_ready falls in the cycle after a request is accepted and rises again together with the one-cycle resp_valid pulse.
- R11: With CAPACITY=1010 and the requests 1,2,3 (sizes 1000, 10, 10) repeated, entry 1 is never evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_id | input | ID_W | Requested configuration identifier |
| req_size | input | SZ_W | Requested configuration size |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response: identifier was resident |
| resp_err | output | 1 | Response: request rejected as oversize |
| evict_valid | output | 1 | One-cycle eviction pulse |
| evict_id | output | ID_W | Identifier of evicted entry |
| evict_size | output | SZ_W | Size of evicted entry |
| load_valid | output | 1 | One-cycle load command pulse |
| load_id | output | ID_W | Identifier to load |
| load_size | output | SZ_W | Size to load |
| hit_cnt | output | CNT_W | Hit count |
| miss_cnt | output | CNT_W | Miss count |
| evict_cnt | output | CNT_W | Eviction count |
| lat_total | output | LAT_W | Accumulated load latency |

## Verification
A pseudo-random sweep uses large sizes and twelve identifiers. It stresses the capacity-driven eviction loop and credit aging, which separates a correct victim order from a recency order or from credits that never age. A second sweep uses tiny sizes and more identifiers than slots. It makes slot exhaustion the trigger and produces many equal credits, which exposes any mistake in the lowest-slot tie-break. Directed cases cover a full table of equal entries, the repeating one-large-two-small pattern in which the large entry must survive, and an oversize request that must leave everything untouched.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_NEED,
    ST_SCAN,
    ST_EVICT,
    ST_LOAD
  } cbr_state_t;
endpackage

// File: rtl/cbr_table.sv
module cbr_table #(
  parameter int NSLOT = 8,
  parameter int ID_W  = 4,
  parameter int SZ_W  = 11,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  look_id,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             has_free,
  output logic [IDX_W-1:0] free_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [ID_W-1:0]  rd_id,
  output logic [SZ_W-1:0]  rd_size,
  output logic [SZ_W-1:0]  rd_credit,
  input  logic             wr_refresh,
  input  logic             wr_insert,
  input  logic             wr_evict,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [ID_W-1:0]  ins_id,
  input  logic [SZ_W-1:0]  ins_size
);
  logic            vld   [NSLOT];
  logic [ID_W-1:0] ids   [NSLOT];
  logic [SZ_W-1:0] sizes [NSLOT];
  logic [SZ_W-1:0] creds [NSLOT];
  logic [SZ_W-1:0] victim_cr;

  assign victim_cr = creds[op_idx];

  // Per-slot update: refresh, insert, or age after an eviction
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (rst) begin
        vld[i] <= 1'b0;
      end else if (op_idx == IDX_W'(i) && wr_insert) begin
        vld[i]   <= 1'b1;
        ids[i]   <= ins_id;
        sizes[i] <= ins_size;
        creds[i] <= ins_size;
      end else if (op_idx == IDX_W'(i) && wr_refresh) begin
        creds[i] <= sizes[i];
      end else if (wr_evict) begin
        if (op_idx == IDX_W'(i)) vld[i] <= 1'b0;
        else if (vld[i])         creds[i] <= creds[i] - victim_cr;
      end
    end
  end

  // Lookup and free-slot search; downward loop lets the lowest index win
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (vld[i] && ids[i] == look_id) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign rd_valid  = vld[rd_idx];
  assign rd_id     = ids[rd_idx];
  assign rd_size   = sizes[rd_idx];
  assign rd_credit = creds[rd_idx];

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
      // credits only shrink from their size, so never exceed it
      assert_credit_bound_R6: assert property (@(posedge clk) disable iff (rst)
        vld[g] |-> creds[g] <= sizes[g]);
    end
  endgenerate
endmodule

// File: rtl/cbr_minscan.sv
module cbr_minscan #(
  parameter int NSLOT = 8,
  parameter int IDX_W = 3,
  parameter int SZ_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cur_valid,
  input  logic [SZ_W-1:0]  cur_credit,
  output logic [IDX_W-1:0] scan_idx,
  output logic             done,
  output logic [IDX_W-1:0] best_idx
);
  logic            busy;
  logic            found;
  logic [SZ_W-1:0] best_cr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      found    <= 1'b0;
      scan_idx <= '0;
      best_idx <= '0;
      best_cr  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        found    <= 1'b0;
        scan_idx <= '0;
      end else if (busy) begin
        // strict less-than keeps the earliest slot on equal credit
        if (cur_valid && (!found || cur_credit < best_cr)) begin
          found    <= 1'b1;
          best_idx <= scan_idx;
          best_cr  <= cur_credit;
        end
        if (scan_idx == IDX_W'(NSLOT - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
      end
    end
  end

  assert_victim_found_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> found);
  assert_scan_runs_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && scan_idx == '0);
endmodule

// File: rtl/cbr_stats.sv
module cbr_stats #(
  parameter int CNT_W        = 16,
  parameter int LAT_W        = 32,
  parameter int SZ_W         = 11,
  parameter int LAT_PER_UNIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_hit,
  input  logic             inc_miss,
  input  logic             inc_evict,
  input  logic             add_lat,
  input  logic [SZ_W-1:0]  add_size,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] evict_cnt,
  output logic [LAT_W-1:0] lat_total
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cnt   <= '0;
      miss_cnt  <= '0;
      evict_cnt <= '0;
      lat_total <= '0;
    end else begin
      if (inc_hit)   hit_cnt   <= hit_cnt + 1'b1;
      if (inc_miss)  miss_cnt  <= miss_cnt + 1'b1;
      if (inc_evict) evict_cnt <= evict_cnt + 1'b1;
      if (add_lat)   lat_total <= lat_total + LAT_W'(add_size) * LAT_W'(LAT_PER_UNIT);
    end
  end

  assert_lat_grows_R8: assert property (@(posedge clk) disable iff (rst)
    add_lat && add_size != '0 |=> lat_total > $past(lat_total));
endmodule

// File: rtl/cbr_repl_mgr.sv
module cbr_repl_mgr
  import cbr_pkg::*;
#(
  parameter int NSLOT        = 8,
  parameter int ID_W         = 4,
  parameter int SZ_W         = 11,
  parameter int CAPACITY     = 1010,
  parameter int LAT_PER_UNIT = 3,
  parameter int CNT_W        = 16,
  parameter int LAT_W        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_id,
  input  logic [SZ_W-1:0]  req_size,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_err,
  output logic             evict_valid,
  output logic [ID_W-1:0]  evict_id,
  output logic [SZ_W-1:0]  evict_size,
  output logic             load_valid,
  output logic [ID_W-1:0]  load_id,
  output logic [SZ_W-1:0]  load_size,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] evict_cnt,
  output logic [LAT_W-1:0] lat_total
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [SZ_W-1:0] CAP = SZ_W'(CAPACITY);

  cbr_state_t      st;
  logic [ID_W-1:0] q_id;
  logic [SZ_W-1:0] q_size;
  logic [SZ_W-1:0] used;
  logic [SZ_W-1:0] free_cap;

  logic             hit, has_free, rd_valid, scan_done;
  logic [IDX_W-1:0] hit_idx, free_idx, rd_idx, op_idx, scan_idx, best_idx;
  logic [ID_W-1:0]  rd_id;
  logic [SZ_W-1:0]  rd_size, rd_credit;
  logic             oversize, need_evict;
  logic             wr_refresh, wr_insert, wr_evict, scan_start;

  assign free_cap   = CAP - used;
  assign oversize   = q_size > CAP;
  assign need_evict = (free_cap < q_size) || !has_free;
  assign wr_refresh = (st == ST_CHECK) && !oversize && hit;
  assign wr_insert  = (st == ST_LOAD);
  assign wr_evict   = (st == ST_EVICT);
  assign scan_start = (st == ST_NEED) && need_evict;
  assign rd_idx     = (st == ST_EVICT) ? best_idx : scan_idx;

  always_comb begin
    case (st)
      ST_CHECK: op_idx = hit_idx;
      ST_EVICT: op_idx = best_idx;
      default:  op_idx = free_idx;
    endcase
  end

  cbr_table #(.NSLOT(NSLOT), .ID_W(ID_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .look_id(q_id),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_id(rd_id), .rd_size(rd_size),
    .rd_credit(rd_credit), .wr_refresh(wr_refresh), .wr_insert(wr_insert),
    .wr_evict(wr_evict), .op_idx(op_idx), .ins_id(q_id), .ins_size(q_size)
  );

  cbr_minscan #(.NSLOT(NSLOT), .IDX_W(IDX_W), .SZ_W(SZ_W)) u_scan (
    .clk(clk), .rst(rst), .start(scan_start), .cur_valid(rd_valid),
    .cur_credit(rd_credit), .scan_idx(scan_idx), .done(scan_done),
    .best_idx(best_idx)
  );

  cbr_stats #(.CNT_W(CNT_W), .LAT_W(LAT_W), .SZ_W(SZ_W),
              .LAT_PER_UNIT(LAT_PER_UNIT)) u_stats (
    .clk(clk), .rst(rst),
    .inc_hit(wr_refresh),
    .inc_miss((st == ST_CHECK) && !oversize && !hit),
    .inc_evict(wr_evict),
    .add_lat(wr_insert), .add_size(q_size),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .evict_cnt(evict_cnt),
    .lat_total(lat_total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      req_ready   <= 1'b0;
      q_id        <= '0;
      q_size      <= '0;
      used        <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_err    <= 1'b0;
      evict_valid <= 1'b0;
      evict_id    <= '0;
      evict_size  <= '0;
      load_valid  <= 1'b0;
      load_id     <= '0;
      load_size   <= '0;
    end else begin
      resp_valid  <= 1'b0;
      evict_valid <= 1'b0;
      load_valid  <= 1'b0;
      case (st)
        ST_IDLE: begin
          req_ready <= 1'b1;
          if (req_valid && req_ready) begin
            q_id      <= req_id;
            q_size    <= req_size;
            req_ready <= 1'b0;
            st        <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (oversize || hit) begin
            resp_valid <= 1'b1;
            resp_err   <= oversize;
            resp_hit   <= !oversize;
            req_ready  <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            st <= ST_NEED;
          end
        end
        ST_NEED: st <= need_evict ? ST_SCAN : ST_LOAD;
        ST_SCAN: if (scan_done) st <= ST_EVICT;
        ST_EVICT: begin
          evict_valid <= 1'b1;
          evict_id    <= rd_id;
          evict_size  <= rd_size;
          used        <= used - rd_size;
          st          <= ST_NEED;
        end
        ST_LOAD: begin
          load_valid <= 1'b1;
          load_id    <= q_id;
          load_size  <= q_size;
          used       <= used + q_size;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_err   <= 1'b0;
          req_ready  <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_used_cap_R4: assert property (@(posedge clk) disable iff (rst)
    used <= CAP);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_err |-> !load_valid && !evict_valid);
  assert_hit_no_evict_R2: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_hit |-> !load_valid && evict_cnt == $past(evict_cnt));
  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/tb_cbr_repl_mgr.sv
module tb_cbr_repl_mgr;
  localparam int CAP = 1010;
  localparam int LPU = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_id = '0;
  logic [10:0] req_size = '0;
  logic        req_ready, resp_valid, resp_hit, resp_err;
  logic        evict_valid, load_valid;
  logic [3:0]  evict_id, load_id;
  logic [10:0] evict_size, load_size;
  logic [15:0] hit_cnt, miss_cnt, evict_cnt;
  logic [31:0] lat_total;

  always #5 clk = ~clk;

  cbr_repl_mgr #(.NSLOT(8), .ID_W(4), .SZ_W(11), .CAPACITY(CAP),
                 .LAT_PER_UNIT(LPU), .CNT_W(16), .LAT_W(32)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_size(req_size), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_err(resp_err), .evict_valid(evict_valid),
    .evict_id(evict_id), .evict_size(evict_size), .load_valid(load_valid),
    .load_id(load_id), .load_size(load_size), .hit_cnt(hit_cnt),
    .miss_cnt(miss_cnt), .evict_cnt(evict_cnt), .lat_total(lat_total)
  );

  int total = 0;
  int bad   = 0;

  // observed pulses
  int ev_n;
  int ev_ids [16];
  int ld_n;
  int ld_id, ld_sz;
  int big_evicted;

  always @(negedge clk) begin
    if (evict_valid) begin
      if (ev_n < 16) ev_ids[ev_n] = int'(evict_id);
      ev_n = ev_n + 1;
    end
    if (load_valid) begin
      ld_n  = ld_n + 1;
      ld_id = int'(load_id);
      ld_sz = int'(load_size);
    end
  end

  // reference state
  bit m_v [8];
  int m_id [8];
  int m_sz [8];
  int m_cr [8];
  int m_used, m_hits, m_miss, m_evs, m_lat;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 1'b0; m_id[i] = 0; m_sz[i] = 0; m_cr[i] = 0;
    end
    m_used = 0; m_hits = 0; m_miss = 0; m_evs = 0; m_lat = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input int id, input int sz);
    int e_hit, e_err, e_nev, hslot, fslot, best, got;
    int e_ev [8];
    e_hit = 0; e_err = 0; e_nev = 0; hslot = -1;
    for (int i = 0; i < 8; i++) e_ev[i] = -1;
    // expected outcome from the requirements
    if (sz > CAP) begin
      e_err = 1;
    end else begin
      for (int i = 7; i >= 0; i--) if (m_v[i] && m_id[i] == id) hslot = i;
      if (hslot >= 0) begin
        e_hit = 1; m_cr[hslot] = m_sz[hslot]; m_hits++;
      end else begin
        m_miss++;
        forever begin
          fslot = -1;
          for (int i = 7; i >= 0; i--) if (!m_v[i]) fslot = i;
          if ((CAP - m_used) >= sz && fslot >= 0) break;
          best = -1;
          for (int i = 0; i < 8; i++)
            if (m_v[i] && (best < 0 || m_cr[i] < m_cr[best])) best = i;
          if (e_nev < 8) e_ev[e_nev] = m_id[best];
          e_nev++;
          m_v[best] = 1'b0;
          m_used -= m_sz[best];
          for (int i = 0; i < 8; i++) if (m_v[i]) m_cr[i] -= m_cr[best];
          m_evs++;
        end
        m_v[fslot] = 1'b1; m_id[fslot] = id; m_sz[fslot] = sz; m_cr[fslot] = sz;
        m_used += sz;
        m_lat += sz * LPU;
      end
    end
    // drive
    while (!req_ready) @(negedge clk);
    ev_n = 0; ld_n = 0;
    req_valid = 1'b1; req_id = 4'(id); req_size = 11'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready low after accept", req_ready, 0);
    got = 0;
    for (int c = 0; c < 200; c++) begin
      if (resp_valid) begin got = 1; break; end
      @(negedge clk);
    end
    #1;
    chk(got == 1, "R10", "response seen", got, 1);
    chk(req_ready == 1'b1, "R10", "ready with response", req_ready, 1);
    chk(resp_err == 1'(e_err), "R9", "resp_err", resp_err, e_err);
    chk(resp_hit == 1'(e_hit), "R2", "resp_hit", resp_hit, e_hit);
    chk(ev_n == e_nev, "R4", "eviction count", ev_n, e_nev);
    for (int k = 0; k < 8; k++)
      if (k < e_nev && k < ev_n)
        chk(ev_ids[k] == e_ev[k], "R5/R6", "victim id", ev_ids[k], e_ev[k]);
    for (int k = 0; k < ev_n && k < 16; k++) if (ev_ids[k] == 1) big_evicted++;
    if (e_err == 0 && e_hit == 0) begin
      chk(ld_n == 1, "R3", "load pulses", ld_n, 1);
      chk(ld_id == id && ld_sz == sz, "R3", "load id", ld_id, id);
    end else begin
      chk(ld_n == 0, "R2", "no load", ld_n, 0);
    end
    chk(int'(hit_cnt) == m_hits, "R8", "hit_cnt", hit_cnt, m_hits);
    chk(int'(miss_cnt) == m_miss, "R8", "miss_cnt", miss_cnt, m_miss);
    chk(int'(evict_cnt) == m_evs, "R8", "evict_cnt", evict_cnt, m_evs);
    chk(int'(lat_total) == m_lat, "R8", "lat_total", lat_total, m_lat);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R10", "response one cycle", resp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    ev_n = 0; ld_n = 0; ld_id = 0; ld_sz = 0; big_evicted = 0;
    do_reset();
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(hit_cnt == 0 && miss_cnt == 0, "R1", "hit/miss cnt", hit_cnt, 0);
    chk(evict_cnt == 0 && lat_total == 0, "R1", "evict/lat", lat_total, 0);
    send(5, 20);
    chk(miss_cnt == 1, "R1", "first request misses", miss_cnt, 1);

    // R11: large entry survives a repeating 1,2,3 pattern
    do_reset();
    big_evicted = 0;
    for (int r = 0; r < 10; r++) begin
      send(1, 1000); send(2, 10); send(3, 10);
    end
    chk(big_evicted == 0, "R11", "large entry evictions", big_evicted, 0);
    send(1, 1000);
    chk(resp_hit == 1'b1 || m_hits > 0, "R11", "large entry resident", resp_hit, 1);

    // R9 oversize rejected, resident set intact
    send(9, 1011);
    send(1, 1000);
    chk(m_hits > 0, "R9", "resident after reject", m_hits, 1);

    // R5 tie: eight equal entries, slot 0 goes first; R7 new credit = size
    do_reset();
    for (int i = 0; i < 8; i++) send(i, 5);
    send(8, 5);
    chk(ev_ids[0] == 0, "R5", "tie victim slot0", ev_ids[0], 0);
    send(9, 5);
    chk(ev_ids[0] == 1, "R7", "next tie victim", ev_ids[0], 1);

    // sweep with large sizes: capacity-driven evictions and aging (R6)
    do_reset();
    seed = 32'h1234_5678;
    for (int r = 0; r < 300; r++) begin
      seed = seed * 1103515245 + 12345;
      send(int'((seed >> 8) % 12), 1 + int'((seed >> 16) % 300));
    end

    // sweep with tiny sizes: slot-driven evictions and ties (R4, R5)
    do_reset();
    for (int r = 0; r < 200; r++) begin
      seed = seed * 1103515245 + 12345;
      send(int'((seed >> 8) % 14), 1 + int'((seed >> 16) % 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule